// File: doc/BRIEF.md
# Banked Flash Query Read Formatter

This block forms the read word a host sees when a bank of identical flash devices, placed side by side on one wide data bus, is in identifier, query or status mode. The host presents a byte address, an access size and a mode. The block turns the address into a per-device table index, fetches one byte from a fixed query table, from the identifier codes or from the status input, and writes that byte into every device lane of the returned word. The result is registered, so it appears one clock after the read strobe.

The geometry of the bank is set by three elaboration parameters: the bank width, the width each device is used at, and the widest mode each device supports. The index is the address shifted right by log2(bank) + log2(max device) - log2(device). Only 1, 2 or 4 bytes are legal. A narrower-than-native device is supported only in byte mode, with a bank of at most 4 bytes. Other combinations stop elaboration. The default build is a 2-byte bank of 16-bit parts used in byte mode, so the index shift is 2.

Top module: `flash_query_fmt`

## Requirements
- R1: After reset, rdValid is 0 and rdData is 0.
- R2: In query mode (mode 2), the table index is the address shifted right by the geometry shift (2 by default). Address bits below the shift have no effect.
- R3: In query mode, any table index of 0x52 or above returns 0. The full index is compared, so index 0x110 returns 0 and not the entry at 0x10.
- R4: When a device is used narrower than its native width, a query byte fills every byte of that device instead of being zero-padded. Each device response is then copied into every device slot of the bank slice.
- R5: In identifier mode (mode 1), only the low 8 bits of the index are used. Index 0 returns MFR_CODE, index 1 returns PART_CODE, and every other index (including 2 and 3) returns 0. Each code sits in the low byte of every device slot.
- R6: An access wider than the bank is split into bank-width slices. The slice at byte lane j uses address + j*BANK_W, and slices are packed from lane 0 upward.
- R7: In status mode (mode 0), statusByte is written into the low byte of every device-width slot within the access.
- R8: accSize selects the access size: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. Bytes above the access size read as 0.
- R9: The query table holds 0x51,0x52,0x59 at 0x10-0x12, 0x01,0x00 at 0x13-0x14, 0x31,0x00 at 0x15-0x16, and 0x50,0x52,0x49,0x31,0x30 at 0x31-0x35. Every other entry is 0.
- R10: A read strobe loads rdData on the next clock edge, and rdValid is high for exactly that one cycle. Without a strobe, rdData holds its value.
- R11: Mode 3 is idle: a read in mode 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe |
| mode | input | 2 | 0 status, 1 identifier, 2 query, 3 idle |
| accSize | input | 2 | Access size code (0:1B, 1:2B, 2/3:4B) |
| addr | input | ADDR_W | Bus byte address |
| statusByte | input | 8 | Current status value to replicate |
| rdData | output | 32 | Formatted read word |
| rdValid | output | 1 | High the cycle rdData is updated |

## Verification
The bench targets four corner cases:
- Wide query reads that span two bank slices. A design that used the wrong offset for the upper slice would return the same table entry twice instead of the next one.
- Indices at and above the table end, including 0x110. A design that clipped the index to 8 bits would return 'Q' there instead of 0.
- Identifier reads at indices 2 and 3, and with high address bits set. These catch a design that decodes the lock offsets or that compares the full index.
- Byte-sized and status accesses. A design that failed to mask unused upper lanes, or that placed status only in lane 0, would show nonzero or missing upper bytes.

// File: rtl/flashq_pkg.sv
package flashq_pkg;

  localparam int BUS_BYTES = 4;
  localparam int QROM_LEN  = 'h52;

  typedef enum logic [1:0] {
    MODE_STATUS = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_QUERY  = 2'd2,
    MODE_NONE   = 2'd3
  } qmode_e;

  typedef struct packed {
    logic                 load;
    logic                 selStatus;
    logic                 selIdent;
    logic                 selQuery;
    logic [BUS_BYTES-1:0] laneMask;
  } fmtStrobe_t;

  function automatic logic [7:0] queryRom(input logic [6:0] idx);
    logic [7:0] b;
    case (idx)
      7'h10: b = 8'h51;
      7'h11: b = 8'h52;
      7'h12: b = 8'h59;
      7'h13: b = 8'h01;
      7'h15: b = 8'h31;
      7'h31: b = 8'h50;
      7'h32: b = 8'h52;
      7'h33: b = 8'h49;
      7'h34: b = 8'h31;
      7'h35: b = 8'h30;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic int log2w(input int w);
    return (w >= 4) ? 2 : (w >= 2) ? 1 : 0;
  endfunction

endpackage

// File: rtl/fqf_ctrl.sv
module fqf_ctrl
  import flashq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdEn,
  input  qmode_e     mode,
  input  logic [1:0] accSize,
  output fmtStrobe_t strobe
);

  always_comb begin
    strobe.load      = rdEn;
    strobe.selStatus = rdEn && (mode == MODE_STATUS);
    strobe.selIdent  = rdEn && (mode == MODE_IDENT);
    strobe.selQuery  = rdEn && (mode == MODE_QUERY);
    case (accSize)
      2'd0:    strobe.laneMask = 4'b0001;
      2'd1:    strobe.laneMask = 4'b0011;
      default: strobe.laneMask = 4'b1111;
    endcase
  end

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selStatus, strobe.selIdent, strobe.selQuery}));

  // R8
  mask_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (strobe.laneMask[0] && (strobe.laneMask[3] == strobe.laneMask[2])));

endmodule

// File: rtl/fqf_datapath.sv
module fqf_datapath
  import flashq_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         BANK_W    = 2,
  parameter int         DEV_W     = 1,
  parameter int         MAX_DEV_W = 2,
  parameter logic [7:0] MFR_CODE  = 8'h5A,
  parameter logic [7:0] PART_CODE = 8'h3C
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fmtStrobe_t             strobe,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             statusByte,
  output logic [8*BUS_BYTES-1:0] rdData,
  output logic                   rdValid
);

  localparam int  SHIFT     = log2w(BANK_W) + log2w(MAX_DEV_W) - log2w(DEV_W);
  localparam bit  X8_REPEAT = (DEV_W < MAX_DEV_W);

  logic [8*BUS_BYTES-1:0] nextWord;
  logic [BUS_BYTES-1:0][7:0] laneByte;

  initial begin
    cfg_legal_chk: assert ((BANK_W == 1 || BANK_W == 2 || BANK_W == 4) &&
                           (DEV_W == 1 || DEV_W == 2 || DEV_W == 4) &&
                           (MAX_DEV_W == 1 || MAX_DEV_W == 2 || MAX_DEV_W == 4) &&
                           (DEV_W <= BANK_W) && (DEV_W <= MAX_DEV_W) &&
                           (!X8_REPEAT || (DEV_W == 1 && BANK_W <= 4)) &&
                           (ADDR_W >= 8));
  end

  for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
    localparam int SLICE    = l / BANK_W;
    localparam int IN_DEV   = (l % BANK_W) % DEV_W;
    localparam int ADDR_OFS = SLICE * BANK_W * BANK_W;

    logic [ADDR_W-1:0] sliceAddr;
    logic [ADDR_W-1:0] idx;
    logic [7:0]        qByte;
    logic [7:0]        iByte;

    always_comb begin
      sliceAddr = addr + ADDR_W'(ADDR_OFS);
      idx       = sliceAddr >> SHIFT;
      qByte     = (idx < ADDR_W'(QROM_LEN)) ? queryRom(idx[6:0]) : 8'h00;
      case (idx[7:0])
        8'h00:   iByte = MFR_CODE;
        8'h01:   iByte = PART_CODE;
        default: iByte = 8'h00;
      endcase
      laneByte[l] = 8'h00;
      if (strobe.selQuery && (IN_DEV == 0 || X8_REPEAT)) laneByte[l] = qByte;
      if (strobe.selIdent && IN_DEV == 0)                laneByte[l] = iByte;
      if (strobe.selStatus && (l % DEV_W) == 0)          laneByte[l] = statusByte;
      if (!strobe.laneMask[l])                           laneByte[l] = 8'h00;
    end
  end

  assign nextWord = laneByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.load;
      if (strobe.load) rdData <= nextWord;
    end
  end

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(rdData));

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !rdValid);

  // R8
  byte_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.laneMask == 4'b0001) |=> (rdData[31:8] == '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.selStatus && !strobe.selIdent && !strobe.selQuery)
      |=> (rdData == '0));

  // R7
  status_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selStatus |=> (rdData[7:0] == $past(statusByte)));

  if (X8_REPEAT && BANK_W >= 2) begin : g_rep_chk
    // R4
    repeat_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.selQuery && strobe.laneMask[1]) |=> (rdData[15:8] == rdData[7:0]));
  end

endmodule

// File: rtl/flash_query_fmt.sv
module flash_query_fmt
  import flashq_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter int         BANK_W    = 2,
  parameter int         DEV_W     = 1,
  parameter int         MAX_DEV_W = 2,
  parameter logic [7:0] MFR_CODE  = 8'h5A,
  parameter logic [7:0] PART_CODE = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [1:0]        mode,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        statusByte,
  output logic [31:0]       rdData,
  output logic              rdValid
);

  fmtStrobe_t strobe;

  fqf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdEn    (rdEn),
    .mode    (qmode_e'(mode)),
    .accSize (accSize),
    .strobe  (strobe)
  );

  fqf_datapath #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .DEV_W     (DEV_W),
    .MAX_DEV_W (MAX_DEV_W),
    .MFR_CODE  (MFR_CODE),
    .PART_CODE (PART_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addr       (addr),
    .statusByte (statusByte),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

endmodule

// File: tb/flash_query_fmt_bench.sv
module flash_query_fmt_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  mode = 2'd3;
  logic [1:0]  accSize = 2'd0;
  logic [11:0] addr = '0;
  logic [7:0]  statusByte = '0;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_query_fmt u_flash_query_fmt (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .mode(mode), .accSize(accSize),
    .addr(addr), .statusByte(statusByte), .rdData(rdData), .rdValid(rdValid)
  );

  // {mode, accSize, addr, status, expected}
  localparam int NV = 21;
  localparam logic [55:0] VEC [NV] = '{
    {2'd2, 2'd2, 12'h040, 8'h00, 32'h52525151},
    {2'd2, 2'd2, 12'h048, 8'h00, 32'h01015959},
    {2'd2, 2'd1, 12'h054, 8'h00, 32'h00003131},
    {2'd2, 2'd2, 12'h0C4, 8'h00, 32'h52525050},
    {2'd2, 2'd2, 12'h0CC, 8'h00, 32'h31314949},
    {2'd2, 2'd1, 12'h0D4, 8'h00, 32'h00003030},
    {2'd2, 2'd1, 12'h148, 8'h00, 32'h00000000},
    {2'd2, 2'd1, 12'h440, 8'h00, 32'h00000000},
    {2'd2, 2'd0, 12'h040, 8'h00, 32'h00000051},
    {2'd2, 2'd1, 12'h043, 8'h00, 32'h00005151},
    {2'd1, 2'd1, 12'h000, 8'h00, 32'h00005A5A},
    {2'd1, 2'd1, 12'h004, 8'h00, 32'h00003C3C},
    {2'd1, 2'd1, 12'h008, 8'h00, 32'h00000000},
    {2'd1, 2'd1, 12'h00C, 8'h00, 32'h00000000},
    {2'd1, 2'd2, 12'h000, 8'h00, 32'h3C3C5A5A},
    {2'd1, 2'd1, 12'h404, 8'h00, 32'h00003C3C},
    {2'd0, 2'd2, 12'h000, 8'h80, 32'h80808080},
    {2'd0, 2'd1, 12'h000, 8'hA2, 32'h0000A2A2},
    {2'd0, 2'd0, 12'h000, 8'h91, 32'h00000091},
    {2'd3, 2'd2, 12'h040, 8'h55, 32'h00000000},
    {2'd2, 2'd1, 12'h080, 8'h00, 32'h00000000}
  };

  function automatic string tagOf(input int i);
    case (i)
      0:       return "R6";
      1, 3, 4: return "R6/R9";
      2, 5, 20: return "R9";
      6, 7:    return "R3";
      8:       return "R8";
      9:       return "R2";
      14:      return "R5/R6";
      10, 11, 12, 13, 15: return "R5";
      16, 17:  return "R7";
      18:      return "R7/R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [1:0] m, input logic [1:0] a,
                        input logic [11:0] ad, input logic [7:0] st);
    @(negedge clk);
    mode = m; accSize = a; addr = ad; statusByte = st; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 data", rdData, 32'h0);
    chk("R1 valid", {31'b0, rdValid}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doRead(VEC[i][55:54], VEC[i][53:52], VEC[i][51:40], VEC[i][39:32]);
      chk(tagOf(i), rdData, VEC[i][31:0]);
    end

    // R10: valid pulse and hold
    doRead(2'd2, 2'd2, 12'h040, 8'h00);
    chk("R10 valid", {31'b0, rdValid}, 32'h1);
    chk("R10 data", rdData, 32'h52525151);
    mode = 2'd1; addr = 12'h004;
    @(negedge clk);
    chk("R10 idle valid", {31'b0, rdValid}, 32'h0);
    chk("R10 hold", rdData, 32'h52525151);

    // R4: x8 repeat of a query byte across both bytes of the device
    doRead(2'd2, 2'd1, 12'h0C8, 8'h00);
    chk("R4", rdData, 32'h00005252);

    // R1: reset clears state again
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 rereset data", rdData, 32'h0);
    rstN = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule